// File: doc/BRIEF.md
# Dual-Channel Resampling PCM Mixer

This block plays two independent signed 8-bit sample streams and mixes them into one output sample each time an external rate tick arrives (around 12 kHz in typical use). Each channel keeps a position inside a loop window of sample memory. After every output sample, it adds an 8.8 fixed-point step to that position, so a stored sample can be played faster or slower than it was recorded. The fraction carries from tick to tick, which keeps the average pitch exact.

A loop window starts on a 256-byte boundary. Its length is 256 bytes times a power of two. The position is kept as an offset inside the window, so wrapping needs only an AND mask. Each channel has its own enable and its own volume, which is either full or half. Half volume lets two loud channels sum without clipping. At full volume the sum is clamped to the signed 8-bit range.

After a tick, the block fetches one byte for channel 0 and then one byte for channel 1 over a request/ready read port. It then publishes the mixed sample with a one-cycle valid pulse. A host sets each channel up through a small register write port.

Top module: `pcm_duo_mixer`

## Requirements
- R1: After reset, mix_out is 0, mix_valid is 0 and mem_req is 0. Every channel is disabled, at full volume, with step 0, loop start 0, loop exponent 0 and offset 0.
- R2: A write with cfg_we=1 goes to the channel cfg_ch and takes effect at the next clock edge. The value of cfg_reg selects the field:
  - 0 is control: bit 0 is enable, bit 1 is half volume, bits 4:2 are the loop exponent E.
  - 1 is the 8.8 step.
  - 2 is the loop start: cfg_data[15:8] become address bits 15:8, and the low byte is 0.
  - 3 is the offset: the integer offset becomes cfg_data and the fraction becomes 0.
- R3: After an accepted tick, the channel 0 read comes first and the channel 1 read comes second. Each read address is loop start plus integer offset, modulo 2^AW. mem_req and mem_addr hold steady until mem_rdy is sampled high.
- R4: After each output sample, an enabled channel's 8.8 offset grows by its step. The fraction is kept across ticks.
- R5: The offset wraps by masking it to a window of 256·2^E bytes, with no compare. This works whether or not the loop start is aligned to the window length.
- R6: A channel at half volume contributes its sample shifted right by one bit, arithmetically. A channel at full volume contributes its sample unchanged.
- R7: The sum of the two contributions is clamped to the range −128..127.
- R8: A disabled channel contributes 0, issues no memory read and keeps its offset unchanged.
- R9: mix_valid is a one-cycle pulse once both reads are done. mix_out changes only in that cycle and holds otherwise.
- R10: A tick that arrives while a mix is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Output-rate strobe, one cycle per sample |
| cfg_we | input | 1 | Register write enable |
| cfg_ch | input | 1 | Channel selected by the write |
| cfg_reg | input | 2 | Field select: 0 control, 1 step, 2 loop start, 3 offset |
| cfg_data | input | 16 | Write data |
| mem_req | output | 1 | Sample read request |
| mem_addr | output | AW | Sample read byte address |
| mem_rdy | input | 1 | Read data valid; completes the request |
| mem_data | input | 8 | Sample byte, signed |
| mix_out | output | 8 | Mixed signed sample |
| mix_valid | output | 1 | One-cycle strobe for a new mix_out |

## Verification
The bench targets several corner cases, and each one shows a specific kind of bug:
- Loop wrap, at both the last byte of a 256-byte window and a 512-byte window. A design with a wrong mask would read past the window instead of returning to its start.
- Steps with a fraction of one half. A design that dropped the fraction would repeat or skip the wrong bytes.
- Two full-volume extremes. These catch a missing clamp, which would fold +254 into a negative value. The same bytes at half volume then show whether the shift is arithmetic.
- A channel disabled and later re-enabled must resume at the same address, and a second tick during slow reads must not produce a second pulse.

// File: rtl/pcm_duo_mixer.sv
module pcm_duo_mixer #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cfg_we,
  input  logic          cfg_ch,
  input  logic [1:0]    cfg_reg,
  input  logic [15:0]   cfg_data,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rdy,
  input  logic [7:0]    mem_data,
  output logic [7:0]    mix_out,
  output logic          mix_valid
);
  localparam int OW = AW + 8;

  typedef enum logic [1:0] {IDLE, RD0, RD1, MIX} st_t;
  st_t st;

  logic          en    [2];
  logic          half  [2];
  logic [2:0]    lexp  [2];
  logic [15:0]   step  [2];
  logic [AW-1:0] base  [2];
  logic [OW-1:0] off   [2];
  logic [7:0]    smp   [2];

  logic signed [9:0] part [2];
  logic signed [9:0] sum;
  logic [7:0]        sat;
  logic              cur;

  function automatic logic [OW-1:0] wrap_mask(input logic [2:0] e);
    return {(AW'(256) << e) - AW'(1), 8'hFF};
  endfunction

  assign cur      = (st == RD1);
  assign mem_req  = (st == RD0 || st == RD1) && en[cur];
  assign mem_addr = base[cur] + off[cur][OW-1:8];

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      part[c] = $signed({{2{smp[c][7]}}, smp[c]});
      if (half[c]) part[c] = part[c] >>> 1;
    end
    sum = part[0] + part[1];
    if (sum > 10'sd127)       sat = 8'h7F;
    else if (sum < -10'sd128) sat = 8'h80;
    else                      sat = sum[7:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= IDLE;
      mix_out   <= '0;
      mix_valid <= 1'b0;
      for (int c = 0; c < 2; c++) begin
        en[c]   <= 1'b0;
        half[c] <= 1'b0;
        lexp[c] <= '0;
        step[c] <= '0;
        base[c] <= '0;
        off[c]  <= '0;
        smp[c]  <= '0;
      end
    end else begin
      mix_valid <= 1'b0;
      case (st)
        IDLE: if (tick) st <= RD0;
        RD0, RD1: begin
          if (!en[cur]) begin
            smp[cur] <= '0;
            st       <= (st == RD0) ? RD1 : MIX;
          end else if (mem_rdy) begin
            smp[cur] <= mem_data;
            st       <= (st == RD0) ? RD1 : MIX;
          end
        end
        MIX: begin
          mix_out   <= sat;
          mix_valid <= 1'b1;
          st        <= IDLE;
          for (int c = 0; c < 2; c++)
            if (en[c]) off[c] <= (off[c] + OW'(step[c])) & wrap_mask(lexp[c]);
        end
        default: st <= IDLE;
      endcase
      if (cfg_we) begin
        case (cfg_reg)
          2'd0: begin
            en[cfg_ch]   <= cfg_data[0];
            half[cfg_ch] <= cfg_data[1];
            lexp[cfg_ch] <= cfg_data[4:2];
          end
          2'd1: step[cfg_ch] <= cfg_data;
          2'd2: base[cfg_ch] <= AW'({cfg_data[15:8], 8'h00});
          default: off[cfg_ch] <= {AW'(cfg_data), 8'h00};
        endcase
      end
    end
  end
endmodule

// File: rtl/pcm_duo_mixer_chk.sv
module pcm_duo_mixer_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic          mem_req,
  input logic          mem_rdy,
  input logic [AW-1:0] mem_addr,
  input logic [7:0]    mix_out,
  input logic          mix_valid
);
  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mix_valid |=> !mix_valid);

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rdy && !cfg_we |=> mem_req && $stable(mem_addr));

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mix_valid |-> $stable(mix_out));

  // R3
  req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mix_valid |-> !mem_req);
endmodule

bind pcm_duo_mixer pcm_duo_mixer_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_pcm_duo_mixer.sv
module sim_pcm_duo_mixer;
  logic clk = 0, rst_n = 0, tick = 0, cfg_we = 0, cfg_ch = 0, mem_rdy = 0;
  logic [1:0] cfg_reg = 0;
  logic [15:0] cfg_data = 0;
  logic [7:0] mem_data = 0;
  logic mem_req, mix_valid;
  logic [15:0] mem_addr;
  logic [7:0] mix_out;

  pcm_duo_mixer #(.AW(16)) u0 (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  int wcnt = 0;
  bit slow = 0;
  logic [15:0] log_a [8];
  int log_n = 0;

  bit          m_en [2];
  bit          m_half [2];
  logic [2:0]  m_exp [2];
  logic [15:0] m_step [2];
  logic [15:0] m_base [2];
  logic [23:0] m_off [2];

  function automatic logic [7:0] mem_byte(logic [15:0] a);
    if (a[15:8] == 8'h40) return 8'h7F;
    if (a[15:8] == 8'h50) return 8'h80;
    return 8'((a * 16'd37) ^ (a >> 7));
  endfunction

  function automatic int mixv(int s0, int s1, bit h0, bit h1);
    int v0 = h0 ? (s0 >>> 1) : s0;
    int v1 = h1 ? (s1 >>> 1) : s1;
    int s = v0 + v1;
    if (s > 127) s = 127;
    if (s < -128) s = -128;
    return s;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (mem_rdy) mem_rdy = 0;
    else if (mem_req) begin
      if (wcnt == 0) begin
        mem_rdy = 1;
        mem_data = mem_byte(mem_addr);
        if (log_n < 8) log_a[log_n] = mem_addr;
        log_n++;
        wcnt = slow ? 5 : int'($urandom % 3);
      end else wcnt--;
    end
  end

  task automatic wr(bit ch, logic [1:0] r, logic [15:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_ch = ch; cfg_reg = r; cfg_data = d;
    @(negedge clk);
    cfg_we = 0;
    case (r)
      2'd0: begin m_en[ch] = d[0]; m_half[ch] = d[1]; m_exp[ch] = d[4:2]; end
      2'd1: m_step[ch] = d;
      2'd2: m_base[ch] = {d[15:8], 8'h00};
      default: m_off[ch] = {d, 8'h00};
    endcase
  endtask

  task automatic expect_result(string tag);
    int na = 0;
    int s [2];
    logic [15:0] ea [2];
    for (int c = 0; c < 2; c++) begin
      s[c] = 0;
      if (m_en[c]) begin
        logic [15:0] a = m_base[c] + m_off[c][23:8];
        s[c] = int'($signed(mem_byte(a)));
        ea[na] = a;
        na++;
      end
    end
    chk(log_n == na, {tag, " R8 read count"}, log_n, na);
    for (int i = 0; i < na && i < log_n; i++)
      chk(log_a[i] == ea[i], {tag, " R3 read address"}, int'(log_a[i]), int'(ea[i]));
    chk(int'($signed(mix_out)) == mixv(s[0], s[1], m_half[0], m_half[1]),
        {tag, " R7 mix value"}, int'($signed(mix_out)), mixv(s[0], s[1], m_half[0], m_half[1]));
    for (int c = 0; c < 2; c++)
      if (m_en[c])
        m_off[c] = (m_off[c] + {8'h00, m_step[c]}) & {((16'd256 << m_exp[c]) - 16'd1), 8'hFF};
  endtask

  task automatic do_tick(string tag);
    int n = 0;
    log_n = 0;
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    while (!mix_valid && n < 200) begin @(negedge clk); n++; end
    chk(mix_valid, {tag, " R9 valid pulse seen"}, mix_valid, 1);
    expect_result(tag);
    @(negedge clk);
    chk(!mix_valid, {tag, " R9 pulse one cycle"}, mix_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int c = 0; c < 2; c++) begin
      m_en[c] = 0; m_half[c] = 0; m_exp[c] = 0; m_step[c] = 0; m_base[c] = 0; m_off[c] = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(mix_out == 0, "R1 mix_out", mix_out, 0);
    chk(mix_valid == 0, "R1 mix_valid", mix_valid, 0);
    chk(mem_req == 0, "R1 mem_req", mem_req, 0);

    do_tick("R8 both off");

    wr(0, 2, 16'h1000); wr(0, 3, 16'h0010); wr(0, 1, 16'h0180); wr(0, 0, 16'h0001);
    for (int i = 0; i < 4; i++) do_tick("R4 fractional step");

    wr(1, 2, 16'h2000); wr(1, 3, 16'h00FE); wr(1, 1, 16'h0100); wr(1, 0, 16'h0001);
    for (int i = 0; i < 3; i++) do_tick("R5 wrap 256");
    wr(1, 2, 16'h2100); wr(1, 3, 16'h01FF); wr(1, 0, 16'h0005);
    for (int i = 0; i < 2; i++) do_tick("R5 wrap 512");

    wr(0, 2, 16'h4000); wr(1, 2, 16'h4000); wr(0, 1, 0); wr(1, 1, 0);
    wr(0, 0, 16'h0001); wr(1, 0, 16'h0001);
    do_tick("R7 positive clamp");
    wr(0, 2, 16'h5000); wr(1, 2, 16'h5000);
    do_tick("R7 negative clamp");
    wr(0, 0, 16'h0003); wr(1, 0, 16'h0003);
    do_tick("R6 half negative");
    wr(0, 2, 16'h4000); wr(1, 2, 16'h4000);
    do_tick("R6 half positive");

    wr(0, 2, 16'h1200); wr(0, 1, 16'h0340); wr(0, 0, 16'h0011);
    do_tick("R8 before disable");
    wr(0, 0, 16'h0010);
    do_tick("R8 disabled");
    wr(0, 0, 16'h0011);
    do_tick("R8 resumed");

    begin
      int pulses = 0;
      slow = 1; wcnt = 6; log_n = 0;
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
      repeat (2) @(negedge clk);
      tick = 1;
      @(negedge clk); tick = 0;
      for (int i = 0; i < 60; i++) begin
        if (mix_valid) begin
          pulses++;
          if (pulses == 1) expect_result("R10 busy tick");
        end
        @(negedge clk);
      end
      chk(pulses == 1, "R10 extra tick ignored", pulses, 1);
      slow = 0; wcnt = 0;
    end

    for (int i = 0; i < 200; i++) begin
      if ($urandom % 3 == 0) wr(1'($urandom), 2'($urandom), 16'($urandom));
      do_tick("R2 random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule